// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a byte-wide transmit stream. Software builds a ring of two-word descriptors starting at a fixed base address. Each descriptor gives a status halfword, a byte count and a buffer address. Software then pulses `kick`. From the current ring index, the engine reads descriptors through a single request/acknowledge memory port. For each descriptor that is marked ready, it streams the buffer bytes to the MAC side. When it has finished with a descriptor, it writes the first descriptor word back with the ready flag cleared.

A frame may span several descriptors. The last-of-frame flag on a descriptor marks its final byte with `tx_last`. A CRC flag on that descriptor raises `tx_crc` on the same beat, which asks the MAC to append a checksum. A descriptor whose ready flag is clear ends the run, and `tx_active` then drops. A graceful-stop level lets the engine finish the frame in progress, park the engine, and report a sticky event that software clears by writing 1. Dropping `ctl_enable` aborts all activity and returns the ring index to zero.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset, `tx_active`, `stop_evt`, `mem_req` and `tx_valid` are all 0, and the ring index is 0.
- R2: On a `kick` pulse, the engine's first memory request reads address RING_BASE + 8 × index, which is word 0 of the current descriptor. Word 0 holds the status in bits 31:16 and the length in bits 15:0. Word 1, at +4, holds the buffer byte address. A request holds its address until `mem_ack`.
- R3: For a descriptor with READY (status bit 15) set and a nonzero length, the engine emits exactly length bytes on `tx_data`. They come from consecutive byte addresses starting at the buffer address, where byte lane `addr[1:0]` of the addressed word is used. `tx_last` is high only on the final byte, and only when LAST (status bit 11) is set.
- R4: `tx_crc` is high exactly on a `tx_last` beat whose descriptor has the CRC flag (status bit 10) set, and is low otherwise.
- R5: After its bytes are sent, the descriptor's word 0 is written back with bit 15 cleared and all other bits unchanged. This write completes before any descriptor is read again, so a lone descriptor with WRAP set is sent only once per kick.
- R6: After the write-back, the index becomes 0 if WRAP (status bit 13) was set. Otherwise it advances by one, modulo the ring size.
- R7: Reading a descriptor with READY clear ends the run: `tx_active` falls and the index stays on that descriptor. The next `kick` restarts from it.
- R8: A ready descriptor with length 0 sends no bytes and is still written back with READY cleared. Processing then moves on to the next descriptor.
- R9: While `stop_req` is high, the engine stops after writing back a descriptor that has LAST set, and leaves the following descriptors untouched. Once idle, it sets `stop_evt` exactly once per assertion of `stop_req`. A `kick` is ignored while `stop_req` is high.
- R10: A pulse on `evt_clr` clears `stop_evt`.
- R11: While `ctl_enable` is low, all activity stops on the next cycle (`tx_active`, `mem_req` and `tx_valid` are all 0), and the ring index returns to 0.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller enable; low aborts and zeroes the index |
| kick | input | 1 | One-cycle start pulse (transmit-active register write) |
| stop_req | input | 1 | Graceful-stop request level |
| evt_clr | input | 1 | Write-1-to-clear pulse for the stop event |
| tx_active | output | 1 | Engine is processing descriptors |
| stop_evt | output | 1 | Sticky graceful-stop event |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| tx_valid | output | 1 | Byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_crc | output | 1 | Append CRC after this final byte |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The hardest situation to reach is a graceful stop that lands between frames while ready descriptors still wait in the ring. The bench builds a two-descriptor frame followed by a third ready descriptor. It raises `stop_req` one cycle after the kick, while the first descriptor is still being fetched. The stop must then take effect only at the second descriptor's write-back, and the third descriptor must remain ready in memory. A second hard case is a lone WRAP descriptor, which would loop forever if the write-back were late. The bench counts the bytes it receives and re-reads the descriptor word to check this case.

// File: rtl/txd_pkg.sv
package txd_pkg;
    // Status flag positions inside the 16-bit status halfword (word 0 bits 31:16)
    localparam int STAT_READY = 15;
    localparam int STAT_WRAP  = 13;
    localparam int STAT_LAST  = 11;
    localparam int STAT_CRC   = 10;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RD_W0   = 3'd1,
        S_RD_W1   = 3'd2,
        S_RD_BYTE = 3'd3,
        S_SEND    = 3'd4,
        S_WB      = 3'd5
    } txd_state_e;
endpackage

// File: rtl/txd_ring_index.sv
module txd_ring_index #(
    parameter int             AW        = 32,
    parameter int             IDX_W     = 3,
    parameter logic [AW-1:0]  RING_BASE = '0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wrap,
    output logic [AW-1:0]    w0_addr,
    output logic [AW-1:0]    w1_addr,
    output logic [IDX_W-1:0] idx_next
);
    localparam int DESC_SHIFT = 3;   // two 32-bit words per descriptor
    localparam int WORD_BYTES = 4;

    assign w0_addr  = RING_BASE + (AW'(idx) << DESC_SHIFT);
    assign w1_addr  = w0_addr + AW'(WORD_BYTES);
    assign idx_next = wrap ? '0 : idx + IDX_W'(1);
endmodule

// File: rtl/txd_lane_pick.sv
module txd_lane_pick #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0]         word,
    input  logic [$clog2(BYTES)-1:0]   lane,
    output logic [7:0]                 sel
);
    logic [7:0] lanes [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign sel = lanes[lane];
endmodule

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_enable,
    input  logic             kick,
    input  logic             stop_req,
    input  logic             evt_clr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic [7:0]       lane_byte,
    input  logic [AW-1:0]    w0_addr,
    input  logic [AW-1:0]    w1_addr,
    input  logic [IDX_W-1:0] idx_next,
    input  logic             tx_ready,
    output logic [IDX_W-1:0] idx,
    output logic             wrap_bit,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             tx_crc,
    output logic             tx_active,
    output logic             stop_evt
);
    localparam int HW = 16;

    typedef struct packed {
        txd_state_e      st;
        logic [IDX_W-1:0] idx;
        logic            active;
        logic            evt;
        logic            stop_done;
        logic            kick_pend;
        logic [HW-1:0]   stat;
        logic [HW-1:0]   len;
        logic [HW-1:0]   cnt;
        logic [AW-1:0]   ptr;
        logic [7:0]      data;
    } regs_t;

    regs_t q, d;
    logic  fin;
    logic  rd_ready;

    assign fin      = (q.cnt == q.len - HW'(1));
    assign rd_ready = mem_rdata[HW + STAT_READY];

    always_comb begin
        d = q;
        d.evt = q.evt & ~evt_clr;
        if (!stop_req) d.stop_done = 1'b0;
        if (kick && q.st != S_IDLE) d.kick_pend = 1'b1;

        unique case (q.st)
            S_IDLE: begin
                if (stop_req && !q.stop_done) begin
                    d.evt       = 1'b1;
                    d.stop_done = 1'b1;
                end else if (kick && !stop_req) begin
                    d.st        = S_RD_W0;
                    d.active    = 1'b1;
                    d.kick_pend = 1'b0;
                end
            end
            S_RD_W0: if (mem_ack) begin
                d.stat = mem_rdata[2*HW-1:HW];
                d.len  = mem_rdata[HW-1:0];
                if (!rd_ready) begin
                    if (q.kick_pend) begin
                        d.kick_pend = 1'b0;      // re-read the same slot
                    end else begin
                        d.st     = S_IDLE;
                        d.active = 1'b0;
                    end
                end else if (mem_rdata[HW-1:0] == '0) begin
                    d.st = S_WB;
                end else begin
                    d.st = S_RD_W1;
                end
            end
            S_RD_W1: if (mem_ack) begin
                d.ptr = mem_rdata[AW-1:0];
                d.cnt = '0;
                d.st  = S_RD_BYTE;
            end
            S_RD_BYTE: if (mem_ack) begin
                d.data = lane_byte;
                d.st   = S_SEND;
            end
            S_SEND: if (tx_ready) begin
                if (fin) begin
                    d.st = S_WB;
                end else begin
                    d.cnt = q.cnt + HW'(1);
                    d.st  = S_RD_BYTE;
                end
            end
            S_WB: if (mem_ack) begin
                d.idx = idx_next;
                if (q.stat[STAT_LAST] && stop_req) begin
                    d.st     = S_IDLE;
                    d.active = 1'b0;
                end else begin
                    d.st = S_RD_W0;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (!ctl_enable) begin
            d.st        = S_IDLE;
            d.idx       = '0;
            d.active    = 1'b0;
            d.kick_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = w0_addr;
        unique case (q.st)
            S_RD_W0:   mem_req = 1'b1;
            S_RD_W1:   begin mem_req = 1'b1; mem_addr = w1_addr; end
            S_RD_BYTE: begin mem_req = 1'b1; mem_addr = q.ptr + AW'(q.cnt); end
            S_WB:      begin mem_req = 1'b1; mem_we = 1'b1; end
            default:   ;
        endcase
    end

    always_comb begin
        mem_wdata                 = {q.stat, q.len};
        mem_wdata[HW + STAT_READY] = 1'b0;
    end

    assign idx       = q.idx;
    assign wrap_bit  = q.stat[STAT_WRAP];
    assign tx_valid  = (q.st == S_SEND);
    assign tx_data   = q.data;
    assign tx_last   = tx_valid && fin && q.stat[STAT_LAST];
    assign tx_crc    = tx_last && q.stat[STAT_CRC];
    assign tx_active = q.active;
    assign stop_evt  = q.evt;
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine #(
    parameter int             AW        = 32,
    parameter int             IDX_W     = 3,
    parameter logic [AW-1:0]  RING_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_enable,
    input  logic          kick,
    input  logic          stop_req,
    input  logic          evt_clr,
    output logic          tx_active,
    output logic          stop_evt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          tx_crc,
    input  logic          tx_ready
);
    localparam int WORD_BYTES = 4;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    logic [IDX_W-1:0] idx, idx_next;
    logic             wrap_bit;
    logic [AW-1:0]    w0_addr, w1_addr;
    logic [7:0]       lane_byte;

    txd_ring_index #(.AW(AW), .IDX_W(IDX_W), .RING_BASE(RING_BASE)) u_index (
        .idx      (idx),
        .wrap     (wrap_bit),
        .w0_addr  (w0_addr),
        .w1_addr  (w1_addr),
        .idx_next (idx_next)
    );

    txd_lane_pick #(.BYTES(WORD_BYTES)) u_lane (
        .word (mem_rdata),
        .lane (mem_addr[LANE_W-1:0]),
        .sel  (lane_byte)
    );

    txd_seq #(.AW(AW), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_enable (ctl_enable),
        .kick       (kick),
        .stop_req   (stop_req),
        .evt_clr    (evt_clr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .lane_byte  (lane_byte),
        .w0_addr    (w0_addr),
        .w1_addr    (w1_addr),
        .idx_next   (idx_next),
        .tx_ready   (tx_ready),
        .idx        (idx),
        .wrap_bit   (wrap_bit),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_crc     (tx_crc),
        .tx_active  (tx_active),
        .stop_evt   (stop_evt)
    );
endmodule

// File: rtl/txd_ring_engine_chk.sv
module txd_ring_engine_chk
    import txd_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_enable,
    input logic          evt_clr,
    input logic          stop_req,
    input logic          stop_evt,
    input logic          tx_active,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_crc
);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || !ctl_enable)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_crc_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_crc |-> tx_last && tx_valid);

    p_wb_clears_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[16 + STAT_READY]);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !ctl_enable)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !tx_active && !mem_req && !tx_valid);

    p_evt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt && evt_clr && !stop_req |=> !stop_evt);

    p_send_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_active);
endmodule

bind txd_ring_engine txd_ring_engine_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_enable (ctl_enable),
    .evt_clr    (evt_clr),
    .stop_req   (stop_req),
    .stop_evt   (stop_evt),
    .tx_active  (tx_active),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_crc     (tx_crc)
);

// File: tb/tb_txd_ring_engine.sv
`timescale 1ns/1ps
module tb_txd_ring_engine;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_enable = 1'b1, kick = 1'b0, stop_req = 1'b0, evt_clr = 1'b0;
    logic tx_active, stop_evt, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic tx_valid, tx_last, tx_crc, tx_ready;
    logic [7:0] tx_data;

    always #2.5 clk = ~clk;

    txd_ring_engine #(.AW(AW), .IDX_W(3), .RING_BASE('0)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .kick(kick),
        .stop_req(stop_req), .evt_clr(evt_clr), .tx_active(tx_active),
        .stop_evt(stop_evt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_crc(tx_crc), .tx_ready(tx_ready)
    );

    // Memory model: 64 words, ack one cycle after a request, backdoor port for the bench
    logic [31:0] mem [0:63];
    logic        bd_we = 1'b0;
    logic [5:0]  bd_idx = '0;
    logic [31:0] bd_data = '0;
    logic        ack_r = 1'b0;
    assign mem_ack   = ack_r;
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        ack_r <= mem_req && !ack_r;
        if (bd_we) mem[bd_idx] <= bd_data;
        else if (mem_req && mem_we && ack_r) mem[mem_addr[7:2]] <= mem_wdata;
    end

    // Sink with optional stalls
    logic stall_en = 1'b0;
    int   cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    assign tx_ready = !stall_en || cyc[1];

    // Capture accepted bytes and hold behaviour at the falling edge
    logic [7:0] cap_d [0:255];
    logic       cap_l [0:255];
    logic       cap_c [0:255];
    int  cap_n = 0;
    int  hold_err = 0;
    logic stall_prev = 1'b0;
    logic [7:0] prev_d = '0;
    logic prev_l = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev && !(tx_valid && tx_data == prev_d && tx_last == prev_l))
                hold_err++;
            stall_prev = tx_valid && !tx_ready;
            prev_d = tx_data;
            prev_l = tx_last;
            if (tx_valid && tx_ready) begin
                cap_d[cap_n[7:0]] = tx_data;
                cap_l[cap_n[7:0]] = tx_last;
                cap_c[cap_n[7:0]] = tx_crc;
                cap_n++;
            end
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic set_word(int widx, logic [31:0] val);
        @(negedge clk);
        bd_we = 1'b1; bd_idx = 6'(widx); bd_data = val;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic set_desc(int di, logic [15:0] st, logic [15:0] len, logic [31:0] ptr);
        set_word(2 * di, {st, len});
        set_word(2 * di + 1, ptr);
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic wait_idle(string req);
        int k = 0;
        while (tx_active && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check({req, " run ends"}, 32'(tx_active), 32'd0);
    endtask

    task automatic re_enable();
        @(negedge clk); ctl_enable = 1'b0;
        @(negedge clk); ctl_enable = 1'b1;
    endtask

    task automatic chk_bytes(string req, int first, int ptr, int n);
        for (int i = 0; i < n; i++)
            check(req, 32'(cap_d[(first + i) % 256]), 32'(pat(ptr + i)));
    endtask

    // R1
    task automatic t_reset();
        check("R1 tx_active", 32'(tx_active), 0);
        check("R1 stop_evt", 32'(stop_evt), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
    endtask

    // R3, R4, R5, R2
    task automatic t_single();
        int s;
        set_desc(0, 16'h8C00, 16'd5, 32'h80);
        set_desc(1, 16'h0000, 16'd0, 32'h0);
        s = cap_n;
        pulse_kick();
        check("R2 first read addr", mem_addr, 32'h0);
        wait_idle("R7");
        check("R3 byte count", 32'(cap_n - s), 5);
        chk_bytes("R3 data", s, 'h80, 5);
        for (int i = 0; i < 5; i++) begin
            check("R3 last flag", 32'(cap_l[(s + i) % 256]), (i == 4) ? 1 : 0);
            check("R4 crc flag", 32'(cap_c[(s + i) % 256]), (i == 4) ? 1 : 0);
        end
        check("R5 write-back", mem[0], {16'h0C00, 16'd5});
    endtask

    // R5 single WRAP sent once, R6 wrap back to 0
    task automatic t_wrap_once();
        int s;
        re_enable();
        set_desc(0, 16'hA800, 16'd3, 32'h90);
        s = cap_n;
        pulse_kick();
        wait_idle("R5");
        check("R5 wrap once count", 32'(cap_n - s), 3);
        chk_bytes("R5 data", s, 'h90, 3);
        check("R5 write-back wrap", mem[0], {16'h2800, 16'd3});
        set_desc(0, 16'hA800, 16'd3, 32'h98);
        s = cap_n;
        pulse_kick();
        check("R6 restart at base", mem_addr, 32'h0);
        wait_idle("R6");
        check("R6 count", 32'(cap_n - s), 3);
        chk_bytes("R6 data", s, 'h98, 3);
    endtask

    // R3 multi-descriptor frame, R4 no crc, R6 increment, R12 stalls
    task automatic t_multi();
        int s;
        re_enable();
        set_desc(0, 16'h8000, 16'd2, 32'hA0);
        set_desc(1, 16'h8800, 16'd3, 32'hA5);
        set_desc(2, 16'h0000, 16'd0, 32'h0);
        s = cap_n;
        stall_en = 1'b1;
        pulse_kick();
        wait_idle("R3");
        stall_en = 1'b0;
        check("R3 multi count", 32'(cap_n - s), 5);
        chk_bytes("R3 first buffer", s, 'hA0, 2);
        chk_bytes("R3 second buffer", s + 2, 'hA5, 3);
        for (int i = 0; i < 5; i++) begin
            check("R3 last only at end", 32'(cap_l[(s + i) % 256]), (i == 4) ? 1 : 0);
            check("R4 no crc", 32'(cap_c[(s + i) % 256]), 0);
        end
        check("R12 hold under stall", 32'(hold_err), 0);
        check("R5 wb desc0", mem[0], {16'h0000, 16'd2});
        check("R5 wb desc1", mem[2], {16'h0800, 16'd3});
    endtask

    // R7 resume at stopping index
    task automatic t_resume();
        int s;
        set_desc(2, 16'h8800, 16'd1, 32'hB3);
        set_desc(3, 16'h0000, 16'd0, 32'h0);
        s = cap_n;
        pulse_kick();
        check("R7 resume addr", mem_addr, 32'h10);
        wait_idle("R7");
        check("R7 resume count", 32'(cap_n - s), 1);
        chk_bytes("R7 resume data", s, 'hB3, 1);
    endtask

    // R8 zero length
    task automatic t_zero_len();
        int s;
        re_enable();
        set_desc(0, 16'h8800, 16'd0, 32'hC0);
        set_desc(1, 16'h8800, 16'd2, 32'hC4);
        set_desc(2, 16'h0000, 16'd0, 32'h0);
        s = cap_n;
        pulse_kick();
        wait_idle("R8");
        check("R8 count", 32'(cap_n - s), 2);
        chk_bytes("R8 data from next", s, 'hC4, 2);
        check("R8 wb zero-length", mem[0], {16'h0800, 16'd0});
    endtask

    // R9 graceful stop, R10 clear
    task automatic t_stop();
        int s;
        re_enable();
        set_desc(0, 16'h8000, 16'd2, 32'hD0);
        set_desc(1, 16'h8800, 16'd2, 32'hD4);
        set_desc(2, 16'h8800, 16'd2, 32'hD8);
        set_desc(3, 16'h0000, 16'd0, 32'h0);
        s = cap_n;
        pulse_kick();
        stop_req = 1'b1;
        wait_idle("R9");
        repeat (2) @(negedge clk);
        check("R9 frame finished", 32'(cap_n - s), 4);
        check("R9 next untouched", mem[4], {16'h8800, 16'd2});
        check("R9 event set", 32'(stop_evt), 1);
        pulse_kick();
        repeat (4) @(negedge clk);
        check("R9 kick ignored active", 32'(tx_active), 0);
        check("R9 kick ignored bytes", 32'(cap_n - s), 4);
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
        check("R10 event cleared", 32'(stop_evt), 0);
        repeat (3) @(negedge clk);
        check("R9 event once", 32'(stop_evt), 0);
        stop_req = 1'b0;
        s = cap_n;
        pulse_kick();
        wait_idle("R9");
        check("R9 resume count", 32'(cap_n - s), 2);
        chk_bytes("R9 resume data", s, 'hD8, 2);
    endtask

    // R11 enable drop mid-run
    task automatic t_disable();
        int s;
        int k = 0;
        re_enable();
        set_desc(0, 16'h8800, 16'd1, 32'hE0);
        set_desc(1, 16'h8800, 16'd10, 32'hE8);
        set_desc(2, 16'h0000, 16'd0, 32'h0);
        s = cap_n;
        pulse_kick();
        while (cap_n < s + 3 && k < 500) begin
            @(negedge clk);
            k++;
        end
        ctl_enable = 1'b0;
        @(negedge clk);
        check("R11 active off", 32'(tx_active), 0);
        check("R11 req off", 32'(mem_req), 0);
        check("R11 valid off", 32'(tx_valid), 0);
        ctl_enable = 1'b1;
        repeat (2) @(negedge clk);
        pulse_kick();
        check("R11 index zero", mem_addr, 32'h0);
        check("R11 request live", 32'(mem_req), 1);
        wait_idle("R11");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int w = 0; w < 64; w++) begin
            @(negedge clk);
            bd_we = 1'b1; bd_idx = 6'(w);
            bd_data = (w < 32) ? 32'h0 :
                      {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        end
        @(negedge clk); bd_we = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_wrap_once();
        t_multi();
        t_resume();
        t_zero_len();
        t_stop();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule